// File: doc/BRIEF.md
# HDLC Receive Frame Status Unit

This block sits at the back end of an HDLC receiver. The flag hunting, zero-bit removal, CRC checking and receive buffering all happen upstream, and this block takes only their results. It watches the destuffed bit stream for an abort pattern. It collects the outcome of each frame (CRC verdict, data loss, abort) into one status byte. It raises a level interrupt for the host when a frame ends.

The host reads the status byte while the interrupt is high. It releases the frame with an acknowledge strobe. While the host holds a status, a second frame end is parked in a one-deep pending slot and shown after the acknowledge. An abort stops the receiver until the host issues the receiver-reset strobe. That strobe also clears every status bit and the interrupt.

Top module: `hdlc_rx_status`

## Requirements
- R1: After reset `stat_o` is 0x00 and `irq_o` is low.
- R2: A `frm_end` pulse while the receiver is running and no status is held loads a new status on the next edge and sets `irq_o`. In that status, bit 6 equals `crc_bad`, where 1 means a bad CRC.
- R3: Seven consecutive 1 bits, sampled on `bit_vld` strobes while `frm_act` is high, abort the frame. On the edge that takes the seventh 1, the status gets bit 5 set and bit 6 clear, and `irq_o` rises.
- R4: A 0 bit taken on a strobe restarts the run of ones. Cycles with `bit_vld` low do not count, whatever `bit_val` is.
- R5: After an abort the receiver stays stopped until `rx_rst`. While stopped, `frm_end`, the bit stream and `rx_ovf` have no effect on the status or the interrupt.
- R6: An `rx_ovf` pulse while running sets bit 7 in the status of every later frame end or abort, until `rx_rst`.
- R7: While `irq_o` is high and no acknowledge or reset arrives, `stat_o` does not change.
- R8: A frame end or abort that arrives while a status is held is kept pending. On the next `rx_ack`, `stat_o` takes the pending status and `irq_o` stays high.
- R9: `rx_ack` with nothing pending drops `irq_o` on the next edge, and `stat_o` keeps its value. `irq_o` stays high until that acknowledge.
- R10: `rx_rst` clears the status, the interrupt, the pending slot, the abort state and the overflow memory on the next edge.
- R11: Bits that arrive while `frm_act` is low are not counted toward an abort.
- R12: The pending slot holds only one event. Further events that arrive while it is full are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Strobe marking a valid destuffed bit |
| bit_val | input | 1 | Destuffed bit value |
| frm_act | input | 1 | High between the opening flag and the end of the frame |
| frm_end | input | 1 | One-cycle pulse at the closing flag |
| crc_bad | input | 1 | CRC verdict, valid with `frm_end` (1 means bad) |
| rx_ovf | input | 1 | Pulse when the receive buffer loses data |
| rx_ack | input | 1 | Host acknowledge of the shown status |
| rx_rst | input | 1 | Receiver-reset command |
| stat_o | output | 8 | Status byte: bit 7 overflow, bit 6 CRC error, bit 5 abort |
| irq_o | output | 1 | Level interrupt for a frame end |

## Verification
The bench sends frame ends back to back so that one status is held, one is pending and a third is offered. A design with no pending slot loses the second frame, and one that overwrites the slot reports the third frame instead of the second.

Runs of six ones are broken by a zero, padded with non-strobe cycles, or sent outside a frame. A detector that ignored the strobe or the frame window would abort early.

After an abort, a frame end and an overflow pulse are sent. A design that did not stay inert would raise the interrupt or later show bit 7. A reset issued with an event pending must leave nothing to surface at the next acknowledge.

// File: rtl/hdlc_stat_pkg.sv
package hdlc_stat_pkg;
  localparam int STAT_W  = 8;
  localparam int OVF_BIT = 7;
  localparam int CRC_BIT = 6;
  localparam int ABT_BIT = 5;

  typedef struct packed {
    logic lost;
    logic crc_err;
    logic aborted;
  } rx_flags_t;

  function automatic logic [STAT_W-1:0] pack_status(input rx_flags_t f);
    logic [STAT_W-1:0] s;
    s          = '0;
    s[OVF_BIT] = f.lost;
    s[CRC_BIT] = f.crc_err;
    s[ABT_BIT] = f.aborted;
    return s;
  endfunction
endpackage

// File: rtl/hdlc_abort_det.sv
module hdlc_abort_det #(
  parameter int RUN_LEN = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic bit_vld,
  input  logic bit_val,
  output logic abort_hit
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  logic [CNT_W-1:0] run_q;

  always_comb
    abort_hit = en && bit_vld && bit_val && (run_q == CNT_W'(RUN_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (clr || abort_hit)
      run_q <= '0;
    else if (en && bit_vld)
      run_q <= bit_val ? run_q + 1'b1 : '0;
  end
endmodule

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_rst,
  input  logic              abort_hit,
  input  logic              frm_end,
  input  logic              crc_bad,
  input  logic              rx_ovf,
  output logic              halted,
  output logic              msg_evt,
  output logic [STAT_W-1:0] msg_stat
);
  logic      lost_q;
  rx_flags_t flags;

  always_comb begin
    flags.lost    = lost_q || (rx_ovf && !halted);
    flags.crc_err = frm_end && crc_bad && !abort_hit;
    flags.aborted = abort_hit;
    msg_evt       = !halted && (abort_hit || frm_end);
    msg_stat      = pack_status(flags);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted <= 1'b0;
      lost_q <= 1'b0;
    end else if (rx_rst) begin
      halted <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      if (abort_hit)         halted <= 1'b1;
      if (rx_ovf && !halted) lost_q <= 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_stat_hold.sv
module hdlc_stat_hold #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_rst,
  input  logic              rx_ack,
  input  logic              evt,
  input  logic [STAT_W-1:0] evt_stat,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq_q
);
  logic [STAT_W-1:0] pend_q;
  logic              pend_v;
  logic              ack_eff;

  assign ack_eff = rx_ack && irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
      irq_q  <= 1'b0;
    end else if (rx_rst) begin
      stat_q <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
      irq_q  <= 1'b0;
    end else if (ack_eff) begin
      if (pend_v) begin
        stat_q <= pend_q;
        pend_v <= evt;
        if (evt) pend_q <= evt_stat;
      end else if (evt) begin
        stat_q <= evt_stat;
      end else begin
        irq_q <= 1'b0;
      end
    end else if (irq_q) begin
      if (evt && !pend_v) begin
        pend_q <= evt_stat;
        pend_v <= 1'b1;
      end
    end else if (evt) begin
      stat_q <= evt_stat;
      irq_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_rx_status.sv
module hdlc_rx_status
  import hdlc_stat_pkg::*;
#(
  parameter int RUN_LEN = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic              frm_act,
  input  logic              frm_end,
  input  logic              crc_bad,
  input  logic              rx_ovf,
  input  logic              rx_ack,
  input  logic              rx_rst,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic              abort_hit;
  logic              halted;
  logic              msg_evt;
  logic [STAT_W-1:0] msg_stat;
  logic              det_clr;
  logic              det_en;

  assign det_clr = rx_rst || frm_end || !frm_act;
  assign det_en  = frm_act && !halted;

  hdlc_abort_det #(.RUN_LEN(RUN_LEN)) i_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (det_clr),
    .en       (det_en),
    .bit_vld  (bit_vld),
    .bit_val  (bit_val),
    .abort_hit(abort_hit)
  );

  hdlc_rx_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_rst   (rx_rst),
    .abort_hit(abort_hit),
    .frm_end  (frm_end),
    .crc_bad  (crc_bad),
    .rx_ovf   (rx_ovf),
    .halted   (halted),
    .msg_evt  (msg_evt),
    .msg_stat (msg_stat)
  );

  hdlc_stat_hold #(.STAT_W(STAT_W)) i_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_rst  (rx_rst),
    .rx_ack  (rx_ack),
    .evt     (msg_evt),
    .evt_stat(msg_stat),
    .stat_q  (stat_o),
    .irq_q   (irq_o)
  );
endmodule

// File: rtl/hdlc_rx_status_chk.sv
module hdlc_rx_status_chk #(
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_ack,
  input logic              rx_rst,
  input logic [STAT_W-1:0] stat_o,
  input logic              irq_o,
  input logic              abort_hit,
  input logic              msg_evt,
  input logic              halted
);
  assert_irq_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_evt && !irq_o && !rx_rst |=> irq_o);

  assert_abort_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit && !rx_rst |=> halted);

  assert_stay_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !rx_rst |=> halted);

  assert_no_irq_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !irq_o && !rx_rst |=> !irq_o);

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !rx_ack && !rx_rst |=> $stable(stat_o));

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !rx_ack && !rx_rst |=> irq_o);

  assert_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> (stat_o == '0) && !irq_o && !halted);
endmodule

bind hdlc_rx_status hdlc_rx_status_chk #(.STAT_W(hdlc_stat_pkg::STAT_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_ack   (rx_ack),
  .rx_rst   (rx_rst),
  .stat_o   (stat_o),
  .irq_o    (irq_o),
  .abort_hit(abort_hit),
  .msg_evt  (msg_evt),
  .halted   (halted)
);

// File: tb/test_hdlc_rx_status.sv
`timescale 1ns/1ps
module test_hdlc_rx_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_vld = 0, bit_val = 0, frm_act = 0, frm_end = 0;
  logic       crc_bad = 0, rx_ovf = 0, rx_ack = 0, rx_rst = 0;
  logic [7:0] stat_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    string      tag;
    logic [7:0] stat;
    logic       irq;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  hdlc_rx_status i_hdlc_rx_status (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .frm_act(frm_act), .frm_end(frm_end), .crc_bad(crc_bad), .rx_ovf(rx_ovf),
    .rx_ack(rx_ack), .rx_rst(rx_rst), .stat_o(stat_o), .irq_o(irq_o)
  );

  // Status byte encoding: bit 7 data lost, bit 6 CRC error, bit 5 abort
  function automatic logic [7:0] st(input logic lost, input logic crc, input logic abt);
    return {lost, crc, abt, 5'b0};
  endfunction

  task automatic expect_out(input string tag, input logic [7:0] s, input logic i);
    exp_t e;
    e.tag = tag; e.stat = s; e.irq = i;
    exp_q.push_back(e);
  endtask

  task automatic drive(input logic bv, input logic b, input logic fe, input logic cb,
                       input logic ov, input logic ak, input logic rr);
    @(negedge clk);
    bit_vld = bv; bit_val = b; frm_end = fe; crc_bad = cb;
    rx_ovf = ov; rx_ack = ak; rx_rst = rr;
    @(posedge clk);
    #1;
    bit_vld = 0; bit_val = 0; frm_end = 0; crc_bad = 0;
    rx_ovf = 0; rx_ack = 0; rx_rst = 0;
  endtask

  task automatic ones(input int n);
    for (int k = 0; k < n; k++) drive(1, 1, 0, 0, 0, 0, 0);
  endtask
  task automatic fend(input logic cb); drive(0, 0, 1, cb, 0, 0, 0); endtask
  task automatic ack();                drive(0, 0, 0, 0, 0, 1, 0); endtask
  task automatic rrst();               drive(0, 0, 0, 0, 0, 0, 1); endtask

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (stat_o !== e.stat || irq_o !== e.irq) begin
        errors++;
        $display("FAIL %s: stat=%02h irq=%b, expected stat=%02h irq=%b",
                 e.tag, stat_o, irq_o, e.stat, e.irq);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    expect_out("R1 reset state", 8'h00, 0);

    frm_act = 1;
    drive(1, 0, 0, 0, 0, 0, 0); drive(1, 1, 0, 0, 0, 0, 0); drive(1, 0, 0, 0, 0, 0, 0);
    fend(0);  expect_out("R2 good frame end", st(0, 0, 0), 1);
    ack();    expect_out("R9 ack drops irq", st(0, 0, 0), 0);
    fend(1);  expect_out("R2 bad CRC frame end", st(0, 1, 0), 1);
    fend(0);  expect_out("R7 status frozen", st(0, 1, 0), 1);
    fend(1);  expect_out("R12 third event while pending full", st(0, 1, 0), 1);
    ack();    expect_out("R8 pending shown after ack", st(0, 0, 0), 1);
    ack();    expect_out("R12 no third status", st(0, 0, 0), 0);

    // R4: a zero restarts the run, non-strobe cycles do not count
    ones(6); drive(1, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) drive(0, 1, 0, 0, 0, 0, 0);
    ones(6);  expect_out("R4 no abort after broken run", st(0, 0, 0), 0);
    fend(1);  expect_out("R4 frame ends normally", st(0, 1, 0), 1);
    ack();

    // R11: ones outside a frame are not counted
    frm_act = 0; ones(8); frm_act = 1; ones(6);
    expect_out("R11 ones outside frame ignored", st(0, 1, 0), 0);
    fend(0);  expect_out("R11 frame ends normally", st(0, 0, 0), 1);
    ack();

    // R3: the seventh one aborts
    ones(6);  expect_out("R3 six ones no abort", st(0, 0, 0), 0);
    ones(1);  expect_out("R3 seventh one aborts", st(0, 0, 1), 1);
    ack();    expect_out("R9 ack after abort", st(0, 0, 1), 0);

    // R5: inert until reset
    fend(1);  expect_out("R5 frame end ignored while stopped", st(0, 0, 1), 0);
    ones(7);  expect_out("R5 bits ignored while stopped", st(0, 0, 1), 0);
    drive(0, 0, 0, 0, 1, 0, 0);
    rrst();   expect_out("R10 reset clears abort status", 8'h00, 0);
    fend(0);  expect_out("R5 overflow while stopped not kept", st(0, 0, 0), 1);
    ack();

    // R6: overflow memory across frames
    drive(0, 0, 0, 0, 1, 0, 0);
    expect_out("R6 overflow alone raises nothing", st(0, 0, 0), 0);
    fend(0);  expect_out("R6 overflow in status", st(1, 0, 0), 1);
    ack();
    fend(1);  expect_out("R6 overflow kept with CRC error", st(1, 1, 0), 1);
    ack();
    ones(7);  expect_out("R6 overflow kept with abort", st(1, 0, 1), 1);
    rrst();   expect_out("R10 reset with irq high", 8'h00, 0);
    fend(0);  expect_out("R6 overflow cleared by reset", st(0, 0, 0), 1);
    ack();

    // R10: reset drops a pending event
    fend(1);  expect_out("R10 setup held status", st(0, 1, 0), 1);
    fend(0);
    rrst();   expect_out("R10 reset clears held status", 8'h00, 0);
    ack();    expect_out("R10 pending dropped by reset", 8'h00, 0);
    fend(1);  expect_out("R10 receiver running after reset", st(0, 1, 0), 1);
    ack();

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule